// File: doc/BRIEF.md
# Segmented Address Generation Unit

This unit turns a 16-bit segment value and an offset into a physical address. It works in one of two modes, chosen per request. In real mode the segment is scaled by sixteen and the low 16 bits of the offset are added to it. In protected mode the 16-bit value is read as a selector. The selector picks an entry from one of two small descriptor tables held in registers. Each entry holds a 32-bit base and a 20-bit limit. The unit adds the offset to that base and checks the offset against the limit.

An address-bit-20 mask input can force bit 20 of the result low. This recreates the 1 MB wraparound that older 20-bit parts show when a real-mode sum carries past the top of memory. A write port loads descriptors into either table. Each request gets exactly one registered response on the next cycle: either an address strobe or a fault. The requested privilege bits of the selector come out on a side output.

Top module: `seg_agu`

## Requirements
- R1: While reset is asserted and after it is released with no request, `addr_vld_o`, `fault_o`, `addr_o` and `rpl_o` are all zero.
- R2: In real mode (`prot_mode_i`=0) with the mask inactive, the address is `seg_i`*16 + `off_i[15:0]`, zero-extended to 33 bits. Offset bits 31:16 are ignored and a carry into bit 20 is kept (FFFF:0020 gives 0x100010).
- R3: When `a20_mask_i`=1, bit 20 of the produced address is forced to 0 in either mode (FFFF:0020 gives 0x00010). All other bits are unchanged.
- R4: A request on `req_i` in cycle N gives, in cycle N+1, exactly one of `addr_vld_o` or `fault_o`. A cycle with no request gives neither in the following cycle.
- R5: In protected mode the selector is split as follows: bits 15:3 are the table index, bit 2 selects the table (0 = global, 1 = local), and bits 1:0 are the requested privilege. The privilege bits appear on `rpl_o` with the response. In real mode `rpl_o` is 0.
- R6: In protected mode the address is base + `off_i` (32-bit unsigned), kept to 33 bits so that a carry out of bit 31 appears in bit 32.
- R7: In protected mode an offset greater than the entry's limit faults. An offset equal to the limit does not fault.
- R8: A protected-mode table index of 8 or more faults, for either table.
- R9: Index 0 with table bit 0 is a null selector and faults, whatever its privilege bits. Index 0 with table bit 1 is an ordinary local entry.
- R10: On a fault, `addr_vld_o` stays low and `addr_o` reads zero.
- R11: When `dt_we_i`=1, the port writes `dt_base_i`/`dt_limit_i` into entry `dt_idx_i` of the table chosen by `dt_tbl_i` (0 = global, 1 = local). A request in the same cycle still sees the old entry. Requests from the next cycle on see the new entry.
- R12: A real-mode request never faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Translation request |
| prot_mode_i | input | 1 | 1 = protected mode, 0 = real mode |
| a20_mask_i | input | 1 | 1 = force address bit 20 low |
| seg_i | input | 16 | Segment value or selector |
| off_i | input | 32 | Offset (real mode uses bits 15:0) |
| dt_we_i | input | 1 | Descriptor write enable |
| dt_tbl_i | input | 1 | Table written: 0 global, 1 local |
| dt_idx_i | input | 3 | Entry written |
| dt_base_i | input | 32 | Base written |
| dt_limit_i | input | 20 | Limit written |
| addr_vld_o | output | 1 | Address valid strobe |
| fault_o | output | 1 | Translation fault strobe |
| addr_o | output | 33 | Physical or linear address |
| rpl_o | output | 2 | Requested privilege of the selector |

## Verification
Real-mode inputs are applied twice, with and without the mask. The FFFF:0020 pair separates a kept carry from a dropped one, and offsets with high bits set show whether bits 31:16 leak into the sum. Protected-mode selectors cover several groups:
- offsets at the limit and one past it, which expose an off-by-one in the compare;
- index 8 and index 0 with each table bit, which separate the range fault from the null rule;
- a base near the top of the 32-bit space, which shows whether the carry reaches bit 32.
A write aimed at the entry being translated in the same cycle separates old-entry from new-entry reads. A long stream of mixed requests then runs against a behavioural model.

// File: rtl/seg_agu_pkg.sv
package seg_agu_pkg;
  localparam int BASE_W = 32;
  localparam int LIM_W  = 20;
  localparam int PA_W   = 33;
  localparam int WRAP_BIT = 20;

  typedef struct packed {
    logic [BASE_W-1:0] base;
    logic [LIM_W-1:0]  limit;
  } desc_t;

  // real-mode sum: segment scaled by 16 plus 16-bit offset, 21 significant bits
  function automatic logic [PA_W-1:0] real_linear(input logic [15:0] seg,
                                                  input logic [15:0] off);
    logic [20:0] s;
    s = {1'b0, seg, 4'b0000} + {5'b0, off};
    return {{(PA_W-21){1'b0}}, s};
  endfunction

  // protected-mode sum keeps the carry out of bit 31
  function automatic logic [PA_W-1:0] prot_linear(input logic [BASE_W-1:0] base,
                                                  input logic [31:0] off);
    return {1'b0, base} + {1'b0, off};
  endfunction

  function automatic logic [PA_W-1:0] apply_wrap(input logic [PA_W-1:0] a,
                                                 input logic mask);
    logic [PA_W-1:0] r;
    r = a;
    if (mask) r[WRAP_BIT] = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/seg_desc_table.sv
module seg_desc_table
  import seg_agu_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  desc_t            wdesc,
  input  logic [IDX_W-1:0] ridx,
  output desc_t            rdesc
);
  desc_t ent [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < DEPTH; e++) ent[e] <= '0;
    end else if (we) begin
      for (int e = 0; e < DEPTH; e++)
        if (widx == IDX_W'(e)) ent[e] <= wdesc;
    end
  end

  always_comb begin
    rdesc = '0;
    for (int e = 0; e < DEPTH; e++)
      if (ridx == IDX_W'(e)) rdesc = ent[e];
  end
endmodule

// File: rtl/seg_sel_decode.sv
module seg_sel_decode #(
  parameter int SEG_W = 16,
  parameter int DEPTH = 8,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic [SEG_W-1:0] sel,
  output logic             tbl_local,
  output logic [IDX_W-1:0] ridx,
  output logic             idx_in_range,
  output logic             is_null,
  output logic [1:0]       rpl
);
  localparam int FULL_W = SEG_W - 3;
  logic [FULL_W-1:0] idx_full;

  assign idx_full     = sel[SEG_W-1:3];
  assign tbl_local    = sel[2];
  assign rpl          = sel[1:0];
  assign ridx         = idx_full[IDX_W-1:0];
  assign idx_in_range = (idx_full < FULL_W'(DEPTH));
  assign is_null      = (idx_full == '0) && !tbl_local;
endmodule

// File: rtl/seg_agu.sv
module seg_agu
  import seg_agu_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter int OFF_W = 32,
  parameter int DEPTH = 8,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic             prot_mode_i,
  input  logic             a20_mask_i,
  input  logic [SEG_W-1:0] seg_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic             dt_we_i,
  input  logic             dt_tbl_i,
  input  logic [IDX_W-1:0] dt_idx_i,
  input  logic [BASE_W-1:0] dt_base_i,
  input  logic [LIM_W-1:0] dt_limit_i,
  output logic             addr_vld_o,
  output logic             fault_o,
  output logic [PA_W-1:0]  addr_o,
  output logic [1:0]       rpl_o
);
  localparam int NTBL = 2;

  logic             tbl_local, idx_in_range, is_null;
  logic [IDX_W-1:0] ridx;
  logic [1:0]       sel_rpl;
  desc_t            rd_desc [NTBL];
  desc_t            sel_desc;
  desc_t            wr_desc;

  // named events for the checker
  logic flt_null_w, flt_range_w, flt_limit_w, fault_c;
  logic [PA_W-1:0] lin_c, addr_c;

  seg_sel_decode #(.SEG_W(SEG_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_dec (
    .sel(seg_i), .tbl_local(tbl_local), .ridx(ridx),
    .idx_in_range(idx_in_range), .is_null(is_null), .rpl(sel_rpl)
  );

  assign wr_desc = '{base: dt_base_i, limit: dt_limit_i};

  for (genvar t = 0; t < NTBL; t++) begin : g_tbl
    seg_desc_table #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_tbl (
      .clk(clk), .rst_n(rst_n),
      .we(dt_we_i && (dt_tbl_i == 1'(t))),
      .widx(dt_idx_i), .wdesc(wr_desc),
      .ridx(ridx), .rdesc(rd_desc[t])
    );
  end

  assign sel_desc    = tbl_local ? rd_desc[1] : rd_desc[0];
  assign flt_range_w = prot_mode_i && !idx_in_range;
  assign flt_null_w  = prot_mode_i && idx_in_range && is_null;
  assign flt_limit_w = prot_mode_i && idx_in_range && !is_null &&
                       (off_i > OFF_W'(sel_desc.limit));
  assign fault_c     = flt_range_w || flt_null_w || flt_limit_w;

  assign lin_c  = prot_mode_i ? prot_linear(sel_desc.base, 32'(off_i))
                              : real_linear(16'(seg_i), off_i[15:0]);
  assign addr_c = apply_wrap(lin_c, a20_mask_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_vld_o <= 1'b0;
      fault_o    <= 1'b0;
      addr_o     <= '0;
      rpl_o      <= '0;
    end else begin
      addr_vld_o <= req_i && !fault_c;
      fault_o    <= req_i && fault_c;
      if (req_i) begin
        addr_o <= fault_c ? '0 : addr_c;
        rpl_o  <= prot_mode_i ? sel_rpl : 2'b00;
      end
    end
  end
endmodule

// File: rtl/seg_agu_chk.sv
module seg_agu_chk #(
  parameter int SEG_W = 16,
  parameter int DEPTH = 8,
  parameter int PA_W  = 33
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_i,
  input logic             prot_mode_i,
  input logic             a20_mask_i,
  input logic [SEG_W-1:0] seg_i,
  input logic             addr_vld_o,
  input logic             fault_o,
  input logic [PA_W-1:0]  addr_o,
  input logic             flt_null_w,
  input logic             flt_range_w,
  input logic             flt_limit_w
);
  AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> (addr_vld_o ^ fault_o)); // R4
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> (!addr_vld_o && !fault_o)); // R4
  AST_WRAP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && a20_mask_i) |=> (!addr_o[20] || fault_o)); // R3
  AST_REAL_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !prot_mode_i) |=> !fault_o); // R12
  AST_LIMIT_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && flt_limit_w) |=> fault_o); // R7
  AST_INDEX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && prot_mode_i && (seg_i[SEG_W-1:3] >= (SEG_W-3)'(DEPTH))) |=> fault_o); // R8
  AST_NULL_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && prot_mode_i && (seg_i[SEG_W-1:2] == '0)) |=> fault_o); // R9
  AST_FAULT_KINDS: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flt_null_w, flt_range_w, flt_limit_w})); // R9
  AST_FAULT_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> (addr_o == '0 && !addr_vld_o)); // R10
endmodule

bind seg_agu seg_agu_chk #(.SEG_W(SEG_W), .DEPTH(DEPTH), .PA_W(seg_agu_pkg::PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .prot_mode_i(prot_mode_i),
  .a20_mask_i(a20_mask_i), .seg_i(seg_i), .addr_vld_o(addr_vld_o),
  .fault_o(fault_o), .addr_o(addr_o), .flt_null_w(flt_null_w),
  .flt_range_w(flt_range_w), .flt_limit_w(flt_limit_w)
);

// File: tb/seg_agu_tb_top.sv
module seg_agu_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_i = 1'b0, prot_mode_i = 1'b0, a20_mask_i = 1'b0;
  logic [15:0] seg_i = '0;
  logic [31:0] off_i = '0;
  logic        dt_we_i = 1'b0, dt_tbl_i = 1'b0;
  logic [2:0]  dt_idx_i = '0;
  logic [31:0] dt_base_i = '0;
  logic [19:0] dt_limit_i = '0;
  logic        addr_vld_o, fault_o;
  logic [32:0] addr_o;
  logic [1:0]  rpl_o;

  int tests = 0, fails = 0, cycles = 0;
  bit started = 0;

  always #4 clk = ~clk;

  seg_agu dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .prot_mode_i(prot_mode_i),
    .a20_mask_i(a20_mask_i), .seg_i(seg_i), .off_i(off_i), .dt_we_i(dt_we_i),
    .dt_tbl_i(dt_tbl_i), .dt_idx_i(dt_idx_i), .dt_base_i(dt_base_i),
    .dt_limit_i(dt_limit_i), .addr_vld_o(addr_vld_o), .fault_o(fault_o),
    .addr_o(addr_o), .rpl_o(rpl_o)
  );

  // behavioural reference model
  longint m_base [2][8];
  longint m_lim  [2][8];
  bit     e_vld, e_flt;
  longint e_addr;
  int     e_rpl;
  string  e_tag;

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      e_vld = 0; e_flt = 0; e_addr = 0; e_rpl = 0; e_tag = "R1";
      for (int t = 0; t < 2; t++)
        for (int i = 0; i < 8; i++) begin m_base[t][i] = 0; m_lim[t][i] = 0; end
    end else begin
      if (req_i) begin
        if (!prot_mode_i) begin
          longint a;
          a = longint'(seg_i) * 16 + (longint'(off_i) % 65536);
          if (a20_mask_i && ((a / 1048576) % 2 == 1)) a = a - 1048576;
          e_vld = 1; e_flt = 0; e_addr = a; e_rpl = 0;
          e_tag = a20_mask_i ? "R3" : "R2";
        end else begin
          int idx, ti;
          idx = int'(seg_i) / 8; ti = (int'(seg_i) / 4) % 2;
          e_rpl = int'(seg_i) % 4;
          if (idx >= 8) begin e_flt = 1; e_tag = "R8"; end
          else if (idx == 0 && ti == 0) begin e_flt = 1; e_tag = "R9"; end
          else if (longint'(off_i) > m_lim[ti][idx]) begin e_flt = 1; e_tag = "R7"; end
          else begin e_flt = 0; e_tag = "R6"; end
          e_vld = !e_flt;
          if (e_flt) e_addr = 0;
          else begin
            longint a;
            a = m_base[ti][idx] + longint'(off_i);
            if (a20_mask_i && ((a / 1048576) % 2 == 1)) a = a - 1048576;
            e_addr = a;
          end
          if (dt_we_i && idx < 8 && int'(dt_tbl_i) == ti && int'(dt_idx_i) == idx)
            e_tag = "R11";
        end
      end else begin
        e_vld = 0; e_flt = 0; e_tag = "R4";
      end
      if (dt_we_i) begin
        m_base[dt_tbl_i][dt_idx_i] = longint'(dt_base_i);
        m_lim[dt_tbl_i][dt_idx_i]  = longint'(dt_limit_i);
      end
    end
  end

  task automatic check(string tag, string what, longint got, longint exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("[TB] FAIL %s %s got %h exp %h", tag, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && rst_n) begin
      check(e_tag, "addr_vld", longint'(addr_vld_o), longint'(e_vld));
      check(e_tag == "R2" || e_tag == "R3" ? "R12" : e_tag, "fault",
            longint'(fault_o), longint'(e_flt));
      if (e_vld) check(e_tag, "addr", longint'(addr_o), e_addr);
      if (e_flt) check("R10", "addr", longint'(addr_o), 0);
      if (e_vld || e_flt) check("R5", "rpl", longint'(rpl_o), longint'(e_rpl));
    end
  end

  task automatic drive(bit rq, bit p, bit m, logic [15:0] s, logic [31:0] o,
                       bit we, bit t, int i, logic [31:0] b, logic [19:0] l);
    @(negedge clk);
    req_i = rq; prot_mode_i = p; a20_mask_i = m; seg_i = s; off_i = o;
    dt_we_i = we; dt_tbl_i = t; dt_idx_i = 3'(i); dt_base_i = b; dt_limit_i = l;
  endtask

  task automatic rq(bit p, bit m, logic [15:0] s, logic [31:0] o);
    drive(1, p, m, s, o, 0, 0, 0, 0, 0);
  endtask

  task automatic wr(bit t, int i, logic [31:0] b, logic [19:0] l);
    drive(0, 0, 0, 0, 0, 1, t, i, b, l);
  endtask

  always @(posedge clk) begin
    if (cycles > 100000) begin
      fails++; tests++;
      $display("[TB] FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "vld", longint'(addr_vld_o), 0);
    check("R1", "fault", longint'(fault_o), 0);
    check("R1", "addr", longint'(addr_o), 0);
    check("R1", "rpl", longint'(rpl_o), 0);
    started = 1;

    // R11: load both tables
    for (int i = 0; i < 8; i++) begin
      wr(0, i, 32'h0010_0000 * i + 32'h123, 20'h00FFF + 20'(i) * 20'h100);
      wr(1, i, 32'h0200_0000 + 32'h1000 * i, 20'h000FF + 20'(i) * 20'h10);
    end
    wr(0, 7, 32'hFFFF_FF00, 20'hFFFFF);

    // R2/R3 real mode
    rq(0, 0, 16'hFFFF, 32'h0000_0020);
    rq(0, 1, 16'hFFFF, 32'h0000_0020);
    rq(0, 0, 16'h2000, 32'h0000_0100);
    rq(0, 0, 16'h0000, 32'h0000_0000);
    rq(0, 0, 16'h1234, 32'hABCD_0010);
    rq(0, 1, 16'hF800, 32'h0000_FFFF);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

    // R6/R7 limit edges on global 1 (limit 0x10FF)
    rq(1, 0, 16'h0008, 32'h0);
    rq(1, 0, 16'h000B, 32'h0000_10FF);
    rq(1, 0, 16'h000A, 32'h0000_1100);
    // R8 index range, R9 null
    rq(1, 0, 16'h0040, 32'h0);
    rq(1, 0, 16'hFFFF, 32'h0);
    rq(1, 0, 16'h0000, 32'h0);
    rq(1, 0, 16'h0003, 32'h0);
    rq(1, 0, 16'h0004, 32'h0000_00FF);
    rq(1, 0, 16'h0007, 32'h0000_0100);
    // R6 carry into bit 32, R3 in protected mode
    rq(1, 0, 16'h0038, 32'h0000_0200);
    rq(1, 1, 16'h0038, 32'h0010_0000);
    rq(1, 1, 16'h0028, 32'h0000_0010);
    // R11 same-cycle write to the entry being used
    drive(1, 1'b1, 0, 16'h0010, 32'h10, 1, 0, 2, 32'h0ABC_0000, 20'h00020);
    rq(1, 0, 16'h0010, 32'h10);
    rq(1, 0, 16'h0010, 32'h21);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

    // mixed stream
    for (int n = 0; n < 400; n++) begin
      logic [15:0] s;
      logic [31:0] o;
      s = {13'($urandom % 10), 3'($urandom)};
      o = ($urandom % 4 == 0) ? 32'($urandom) : 32'($urandom % 32'h1400);
      if ($urandom % 8 == 0)
        drive(1, 1'($urandom), 1'($urandom), s, o, 1, 1'($urandom),
              int'($urandom % 8), 32'($urandom), 20'($urandom));
      else if ($urandom % 6 == 0)
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      else
        rq(1'($urandom), 1'($urandom), ($urandom % 3 == 0) ? 16'($urandom) : s, o);
    end
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule